// File: doc/BRIEF.md
# Selectable-Pin Input Capture Unit

This block samples a running 12-bit counter value into a holding register when a chosen edge arrives on one of two asynchronous input pins. A select bit routes either the normal capture pin or the long-capture pin to the capture path. Both pins pass through their own synchronizer and edge detector all the time. The select bit only picks which detected edge is used, so a change of the select bit never produces a capture by itself.

A polarity bit chooses whether rising or falling edges count. Each capture sets a sticky flag, and this flag locks the holding register. Later edges are dropped until software clears the flag with a write-one-to-clear pulse. An interrupt request is raised while the flag is set and its enable is on. The counter itself and the register bus are outside the block. Control bits and the clear pulse arrive as plain inputs.

Top module: `sel_pin_capture`

## Requirements
- R1: While reset is active, and after it is released with no stimulus, cap_val_o is 0, cap_flag_o is 0 and irq_o is 0.
- R2: With edge_fall_i = 0, a 0-to-1 change of the selected pin that is first sampled at clock edge k loads count_i as present at clock edge k+2 into cap_val_o. The new value is visible after edge k+2.
- R3: With edge_fall_i = 1, only 1-to-0 changes of the selected pin capture, with the same latency as R2. Rising changes are ignored.
- R4: With pin_sel_i = 0, only pin_norm_i can cause a capture. Edges on pin_long_i leave cap_val_o and cap_flag_o unchanged.
- R5: With pin_sel_i = 1, only pin_long_i can cause a capture. Edges on pin_norm_i are ignored.
- R6: cap_flag_o rises at the same clock edge that loads cap_val_o.
- R7: While cap_flag_o is 1, no capture takes place and cap_val_o keeps its value.
- R8: A one-cycle flag_clr_i pulse while cap_flag_o is 1 clears the flag at the next edge. If a qualifying edge arrives in the same cycle, it is dropped.
- R9: irq_o is 1 exactly when cap_flag_o is 1 and irq_en_i is 1.
- R10: Changing pin_sel_i or edge_fall_i while the pins are steady causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 12 | Running counter value to be captured |
| pin_norm_i | input | 1 | Normal capture pin, asynchronous |
| pin_long_i | input | 1 | Long-capture pin, asynchronous |
| pin_sel_i | input | 1 | 0 selects pin_norm_i, 1 selects pin_long_i |
| edge_fall_i | input | 1 | 0 captures on rising edges, 1 on falling edges |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the capture flag |
| cap_val_o | output | 12 | Captured counter value |
| cap_flag_o | output | 1 | Capture flag, sticky until cleared |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the two-edge synchronizer latency. A design that captured one cycle early or late would latch a counter value off by one. It drives edges on the pin that is not selected, and a design that muxed the pins before edge detection would capture on a select change. It also drives a clear pulse in the same cycle as a qualifying edge. A design that gave that edge priority would leave the flag set with a fresh value. Finally, it sends edges while the flag is set, which exposes any design that lets the register move while it is locked.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned PIN_NORM = 0;
  localparam int unsigned PIN_LONG = 1;
  localparam int unsigned N_PINS   = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
#(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  edge_pol_e        pol_i,
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  // per-pin detector; polarity only chooses which transition counts
  for (genvar i = 0; i < WIDTH; i++) begin : g_det
    always_comb begin
      if (pol_i == EDGE_FALL) edge_o[i] = prev_q[i] & ~lvl_i[i];
      else                    edge_o[i] = ~prev_q[i] & lvl_i[i];
    end
  end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] val_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] val_q;
  logic             flag_q;
  logic             load;

  // locked while flag set; clear beats a coincident edge
  assign load = edge_i & ~flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      flag_q <= 1'b0;
    end else if (flag_q && clr_i) begin
      flag_q <= 1'b0;
    end else if (load) begin
      val_q  <= count_i;
      flag_q <= 1'b1;
    end
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sel_pin_capture.sv
module sel_pin_capture
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pin_norm_i,
  input  logic             pin_long_i,
  input  logic             pin_sel_i,
  input  logic             edge_fall_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  logic [N_PINS-1:0] pins_raw;
  logic [N_PINS-1:0] pins_sync;
  logic [N_PINS-1:0] pins_edge;
  logic              edge_sel;
  edge_pol_e         pol;

  assign pins_raw[PIN_NORM] = pin_norm_i;
  assign pins_raw[PIN_LONG] = pin_long_i;
  assign pol = edge_pol_e'(edge_fall_i);

  cap_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_raw),
    .sync_o (pins_sync)
  );

  cap_edge #(.WIDTH(N_PINS)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_sync),
    .pol_i (pol),
    .edge_o(pins_edge)
  );

  // select after detection so switching pins cannot fake an edge
  assign edge_sel = pin_sel_i ? pins_edge[PIN_LONG] : pins_edge[PIN_NORM];

  cap_store #(.CNT_W(CNT_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edge_sel),
    .clr_i  (flag_clr_i),
    .count_i(count_i),
    .val_o  (cap_val_o),
    .flag_o (cap_flag_o)
  );

  assign irq_o = cap_flag_o & irq_en_i;
endmodule

// File: rtl/sel_pin_capture_chk.sv
module sel_pin_capture_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             irq_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (cap_val_o == '0 && !cap_flag_o && !irq_o);
    end
  end

  p_load_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_flag_o) |-> cap_val_o == $past(count_i));

  p_hold_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_flag_o |=> $stable(cap_val_o));

  p_change_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_val_o) |-> $rose(cap_flag_o));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o && flag_clr_i) |=> !cap_flag_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cap_flag_o && irq_en_i));

  p_irq_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o && irq_en_i) |-> irq_o);
endmodule

bind sel_pin_capture sel_pin_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_i   (count_i),
  .irq_en_i  (irq_en_i),
  .flag_clr_i(flag_clr_i),
  .cap_val_o (cap_val_o),
  .cap_flag_o(cap_flag_o),
  .irq_o     (irq_o)
);

// File: tb/sel_pin_capture_test.sv
module sel_pin_capture_test;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] count = '0;
  logic          pin_norm = 1'b0, pin_long = 1'b0;
  logic          sel = 1'b0, fall = 1'b0, irq_en = 1'b0, clr = 1'b0;
  logic [CW-1:0] cap_val;
  logic          cap_flag, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "R1";

  always #5 clk = ~clk;

  sel_pin_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count),
    .pin_norm_i(pin_norm), .pin_long_i(pin_long), .pin_sel_i(sel),
    .edge_fall_i(fall), .irq_en_i(irq_en), .flag_clr_i(clr),
    .cap_val_o(cap_val), .cap_flag_o(cap_flag), .irq_o(irq)
  );

  // behavioural reference: history of sampled pins, capture two edges later
  logic [1:0]    hist[$];
  int            m_cap = 0;
  bit            m_flag = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      repeat (4) hist.push_back(2'b00);
      m_cap = 0;
      m_flag = 1'b0;
    end else begin
      bit cur, old, ev;
      int p;
      hist.push_back({pin_long, pin_norm});
      while (hist.size() > 4) void'(hist.pop_front());
      p   = sel ? 1 : 0;
      cur = hist[1][p];
      old = hist[0][p];
      ev  = fall ? (old && !cur) : (!old && cur);
      if (m_flag && clr) m_flag = 1'b0;
      else if (!m_flag && ev) begin
        m_cap  = int'(count);
        m_flag = 1'b1;
      end
    end
    #3;
    check({phase, " cap_val"}, int'(cap_val), m_cap);
    check({phase, " cap_flag"}, int'(cap_flag), int'(m_flag));
    check({phase, " irq R9"}, int'(irq), int'(m_flag && irq_en));
  end

  always @(negedge clk) count <= count + 12'd7;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1: quiet after reset
    check("R1 flag", int'(cap_flag), 0);
    check("R1 val", int'(cap_val), 0);

    // R2, R6: rising edge on normal pin
    phase = "R2";
    pin_norm = 1'b1; cyc(1); pin_norm = 1'b0; cyc(4);
    check("R2 flag set", int'(cap_flag), 1);
    // R9: irq follows enable
    phase = "R9";
    irq_en = 1'b1; cyc(2);
    check("R9 irq", int'(irq), 1);
    // R7: edges while locked
    phase = "R7";
    pin_norm = 1'b1; cyc(2); pin_norm = 1'b0; cyc(4);
    // R8: clear
    phase = "R8";
    clear_flag(); cyc(1);
    check("R8 flag clear", int'(cap_flag), 0);
    check("R9 irq drop", int'(irq), 0);

    // R3: falling polarity
    phase = "R3";
    fall = 1'b1; cyc(2);
    pin_norm = 1'b1; cyc(5);
    check("R3 no rise capture", int'(cap_flag), 0);
    pin_norm = 1'b0; cyc(4);
    check("R3 fall capture", int'(cap_flag), 1);
    clear_flag(); cyc(2);
    fall = 1'b0;

    // R4: long pin ignored with sel=0
    phase = "R4";
    pin_long = 1'b1; cyc(3); pin_long = 1'b0; cyc(4);
    check("R4 long ignored", int'(cap_flag), 0);

    // R10: select and polarity changes with differing steady pins
    phase = "R10";
    pin_long = 1'b1; cyc(4);
    sel = 1'b1; cyc(4);
    fall = 1'b1; cyc(3); fall = 1'b0; cyc(3);
    sel = 1'b0; cyc(4);
    check("R10 no capture", int'(cap_flag), 0);
    pin_long = 1'b0; cyc(4);

    // R5: long pin with sel=1, normal pin ignored
    phase = "R5";
    sel = 1'b1;
    pin_norm = 1'b1; cyc(2); pin_norm = 1'b0; cyc(4);
    check("R5 norm ignored", int'(cap_flag), 0);
    pin_long = 1'b1; cyc(1); pin_long = 1'b0; cyc(4);
    check("R5 long capture", int'(cap_flag), 1);

    // R8: clear coincides with qualifying edge -> dropped
    phase = "R8";
    pin_long = 1'b1; cyc(2);
    clear_flag(); cyc(3);
    check("R8 edge dropped", int'(cap_flag), 0);
    pin_long = 1'b0; cyc(3);

    // back-to-back captures after each clear
    phase = "R2";
    sel = 1'b0;
    for (int i = 0; i < 6; i++) begin
      pin_norm = 1'b1; cyc(1 + i % 2); pin_norm = 1'b0; cyc(3 + i % 3);
      clear_flag(); cyc(1);
    end

    // R1: reset mid-run with flag set
    phase = "R1";
    pin_norm = 1'b1; cyc(1); pin_norm = 1'b0; cyc(4);
    rst_n = 1'b0; cyc(2);
    check("R1 reset flag", int'(cap_flag), 0);
    check("R1 reset val", int'(cap_val), 0);
    rst_n = 1'b1; cyc(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule